// File: doc/BRIEF.md
# Transmit FIFO Start Controller

This block buffers outgoing frame bytes between a DMA-side writer and a MAC-side reader. It decides when the reader may start draining a frame. The writer pushes bytes with a valid/ready handshake and flags the final byte of each frame. The reader pulls bytes with its own handshake. It sees a marker on the first byte of a transmission and another on the last byte of a frame.

Two start policies can be selected at run time. In whole-frame mode the reader is held off until at least one complete frame, including its final byte, is stored. In level mode a 3-bit code selects a byte count, and draining begins when that count is reached. Draining also begins when a complete frame shorter than that count is already stored.

A control write can also request a flush. The flush empties the FIFO and resets its bookkeeping over a fixed number of cycles. The flush indicator then clears by itself. Control writes arriving during a flush are dropped. A change of policy requested while a frame is being drained is held back and applied once the reader is idle.

Top module: `txfifo_start_ctrl`

## Requirements
- R1: After reset, wrReady is 1, rdValid is 0, flushBusy is 0, sfActive is 0 (level mode) and the level code is 0.
- R2: With sfActive=1, rdValid rises within three cycles after the byte carrying wrLast=1 is accepted, and never before that byte has been accepted.
- R3: With sfActive=1, the level code has no effect: a partial frame of any length leaves rdValid at 0.
- R4: With sfActive=0, draining starts once the stored byte count reaches the level chosen by ctrlThresh. Codes 0..7 select 64, 128, 192, 256, 40, 32, 24 and 16 bytes.
- R5: With sfActive=0, a complete frame shorter than the selected level also starts draining.
- R6: Bytes leave in the order they were written. rdFirst is 1 only on the first byte of a transmission, and rdLast is 1 only on a byte written with wrLast=1.
- R7: Reading a frame's last byte ends the transmission. A following stored frame starts its own transmission, with a fresh rdFirst.
- R8: When DEPTH bytes are stored, wrReady is 0 and no further byte is accepted.
- R9: A control write with ctrlFlush=1 sets flushBusy for exactly FLUSH_CYCLES cycles, during which wrReady and rdValid are 0. Afterwards flushBusy clears by itself and no previously stored byte can be read.
- R10: A control write arriving while flushBusy is 1 is ignored, including its mode, level and flush fields.
- R11: A mode change written while txActive is 1 leaves sfActive unchanged until the transmission ends. It is then applied within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Writer offers a byte |
| wrData | input | DATA_W | Byte offered by writer |
| wrLast | input | 1 | Offered byte ends a frame |
| wrReady | output | 1 | FIFO accepts a byte this cycle |
| rdReady | input | 1 | Reader takes a byte |
| rdValid | output | 1 | A byte is available to the reader |
| rdData | output | DATA_W | Byte at the head of the FIFO |
| rdFirst | output | 1 | Head byte opens a transmission |
| rdLast | output | 1 | Head byte ends a frame |
| ctrlWrite | input | 1 | Control write strobe |
| ctrlFlush | input | 1 | Flush request field of the control write |
| ctrlStoreFwd | input | 1 | Whole-frame mode field of the control write |
| ctrlThresh | input | 3 | Level code field of the control write |
| flushBusy | output | 1 | Flush in progress, self-clearing |
| sfActive | output | 1 | Start policy currently in force (1 = whole-frame) |
| txActive | output | 1 | A transmission is in progress |

## Verification
A stale frame counter shows up at the reader. In whole-frame mode, a count that is too high opens rdValid before the final byte has arrived, one cycle after the bad state appears. A count that is too low holds back a fully stored frame indefinitely. A wrong byte count moves the level-mode start earlier or later, and this can be seen on rdValid around the threshold write. A flush that clears too little lets an old byte reach rdData at the first read of the next frame. A policy applied too early appears on sfActive while txActive is still high.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Strobes from the control unit to the storage datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } txf_strobe_t;

  // Start level in bytes for each 3-bit level code.
  function automatic logic [8:0] levelFromCode(input logic [2:0] code);
    logic [8:0] lvl;
    case (code)
      3'd0:    lvl = 9'd64;
      3'd1:    lvl = 9'd128;
      3'd2:    lvl = 9'd192;
      3'd3:    lvl = 9'd256;
      3'd4:    lvl = 9'd40;
      3'd5:    lvl = 9'd32;
      3'd6:    lvl = 9'd24;
      default: lvl = 9'd16;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/txf_datapath.sv
module txf_datapath
  import txf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txf_strobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic [DATA_W-1:0] headData,
  output logic              headLast,
  output logic [CW-1:0]     occupancy,
  output logic [CW-1:0]     frameCnt,
  output logic              full,
  output logic              empty
);

  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic            pushEnd, popEnd;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= {wrLast, wrData};
  end

  assign {headLast, headData} = mem[rdPtr];
  assign pushEnd = stb.push && wrLast;
  assign popEnd  = stb.pop && headLast;
  assign full    = (occupancy == CW'(DEPTH));
  assign empty   = (occupancy == '0);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
      frameCnt  <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
      case ({pushEnd, popEnd})
        2'b10:   frameCnt <= frameCnt + 1'b1;
        2'b01:   frameCnt <= frameCnt - 1'b1;
        default: frameCnt <= frameCnt;
      endcase
    end
  end

endmodule

// File: rtl/txf_control.sv
module txf_control
  import txf_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int FLUSH_CYCLES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FW = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          rdReady,
  input  logic          ctrlWrite,
  input  logic          ctrlFlush,
  input  logic          ctrlStoreFwd,
  input  logic [2:0]    ctrlThresh,
  input  logic [CW-1:0] occupancy,
  input  logic [CW-1:0] frameCnt,
  input  logic          full,
  input  logic          empty,
  input  logic          headLast,
  output txf_strobe_t   stb,
  output logic          wrReady,
  output logic          rdValid,
  output logic          rdFirst,
  output logic          flushBusy,
  output logic          sfActive,
  output logic          txActive
);

  logic          acceptCtrl, flushStart, startOk, levelReached;
  logic [2:0]    threshReg;
  logic          sfPending, firstPending;
  logic [FW-1:0] flushCnt;

  assign acceptCtrl   = ctrlWrite && !flushBusy;
  assign flushStart   = acceptCtrl && ctrlFlush;
  assign levelReached = 32'(occupancy) >= 32'(levelFromCode(threshReg));
  assign startOk      = (frameCnt != '0) || (!sfActive && levelReached);

  assign wrReady   = !full && !flushBusy;
  assign rdValid   = txActive && !empty && !flushBusy;
  assign rdFirst   = rdValid && firstPending;
  assign stb.push  = wrValid && wrReady;
  assign stb.pop   = rdValid && rdReady;
  assign stb.clear = flushBusy;

  // Control register fields and flush sequencing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      threshReg <= '0;
      sfPending <= 1'b0;
      sfActive  <= 1'b0;
      flushBusy <= 1'b0;
      flushCnt  <= '0;
    end else begin
      if (acceptCtrl) begin
        threshReg <= ctrlThresh;
        sfPending <= ctrlStoreFwd;
      end
      if (flushStart) begin
        flushBusy <= 1'b1;
        flushCnt  <= FW'(FLUSH_CYCLES - 1);
      end else if (flushBusy) begin
        if (flushCnt == '0) flushBusy <= 1'b0;
        else                flushCnt  <= flushCnt - 1'b1;
      end
      if (!txActive) sfActive <= sfPending;
    end
  end

  // Transmission state: start decision and end-of-frame detection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive     <= 1'b0;
      firstPending <= 1'b0;
    end else if (flushStart || flushBusy) begin
      txActive     <= 1'b0;
      firstPending <= 1'b0;
    end else if (!txActive) begin
      if (startOk) begin
        txActive     <= 1'b1;
        firstPending <= 1'b1;
      end
    end else if (stb.pop) begin
      firstPending <= 1'b0;
      if (headLast) txActive <= 1'b0;
    end
  end

endmodule

// File: rtl/txfifo_start_ctrl.sv
module txfifo_start_ctrl
  import txf_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int DATA_W       = 8,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic              wrReady,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFirst,
  output logic              rdLast,
  input  logic              ctrlWrite,
  input  logic              ctrlFlush,
  input  logic              ctrlStoreFwd,
  input  logic [2:0]        ctrlThresh,
  output logic              flushBusy,
  output logic              sfActive,
  output logic              txActive
);

  localparam int CW = $clog2(DEPTH + 1);

  txf_strobe_t   stb;
  logic [CW-1:0] occupancy, frameCnt;
  logic          full, empty, headLast;

  txf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .wrLast(wrLast),
    .headData(rdData), .headLast(headLast), .occupancy(occupancy),
    .frameCnt(frameCnt), .full(full), .empty(empty)
  );

  txf_control #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdReady(rdReady),
    .ctrlWrite(ctrlWrite), .ctrlFlush(ctrlFlush), .ctrlStoreFwd(ctrlStoreFwd),
    .ctrlThresh(ctrlThresh), .occupancy(occupancy), .frameCnt(frameCnt),
    .full(full), .empty(empty), .headLast(headLast), .stb(stb),
    .wrReady(wrReady), .rdValid(rdValid), .rdFirst(rdFirst),
    .flushBusy(flushBusy), .sfActive(sfActive), .txActive(txActive)
  );

  assign rdLast = rdValid && headLast;

endmodule

// File: rtl/txf_start_checker.sv
module txf_start_checker #(
  parameter int DEPTH        = 256,
  parameter int FLUSH_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic wrValid,
  input logic wrLast,
  input logic wrReady,
  input logic rdReady,
  input logic rdValid,
  input logic rdFirst,
  input logic rdLast,
  input logic flushBusy,
  input logic sfActive,
  input logic txActive
);

  int unsigned occ, frames, busyRun;
  logic pushH, popH;

  assign pushH = wrValid && wrReady;
  assign popH  = rdValid && rdReady;

  always_ff @(posedge clk) begin
    if (!rstN || flushBusy) begin
      occ    <= 0;
      frames <= 0;
    end else begin
      occ    <= occ + (pushH ? 1 : 0) - (popH ? 1 : 0);
      frames <= frames + ((pushH && wrLast) ? 1 : 0) - ((popH && rdLast) ? 1 : 0);
    end
    if (!rstN) busyRun <= 0;
    else       busyRun <= flushBusy ? busyRun + 1 : 0;
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    occ <= DEPTH);
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (occ == DEPTH) |-> !wrReady);
  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> (!wrReady && !rdValid));
  a_r9_flush_bound: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> (busyRun < FLUSH_CYCLES));
  a_r9_flush_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushBusy) |-> (busyRun == FLUSH_CYCLES));
  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(txActive) |-> $stable(sfActive));
  a_r2_whole_frame: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txActive) && $past(sfActive)) |-> ($past(frames) != 0));
  a_r6_first_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdFirst |-> rdValid);

endmodule

bind txfifo_start_ctrl txf_start_checker #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrLast(wrLast), .wrReady(wrReady),
  .rdReady(rdReady), .rdValid(rdValid), .rdFirst(rdFirst), .rdLast(rdLast),
  .flushBusy(flushBusy), .sfActive(sfActive), .txActive(txActive)
);

// File: tb/test_txfifo_start_ctrl.sv
`timescale 1ns/1ps
module test_txfifo_start_ctrl;

  localparam int DEPTH = 256;
  localparam int FLUSH_CYCLES = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 0, wrLast = 0, rdReady = 0;
  logic [7:0] wrData = '0;
  logic ctrlWrite = 0, ctrlFlush = 0, ctrlStoreFwd = 0;
  logic [2:0] ctrlThresh = '0;
  logic wrReady, rdValid, rdFirst, rdLast, flushBusy, sfActive, txActive;
  logic [7:0] rdData;
  int nChecks = 0, nErr = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txfifo_start_ctrl #(.DEPTH(DEPTH), .DATA_W(8), .FLUSH_CYCLES(FLUSH_CYCLES)) i_txfifo_start_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrLast(wrLast),
    .wrReady(wrReady), .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData),
    .rdFirst(rdFirst), .rdLast(rdLast), .ctrlWrite(ctrlWrite), .ctrlFlush(ctrlFlush),
    .ctrlStoreFwd(ctrlStoreFwd), .ctrlThresh(ctrlThresh), .flushBusy(flushBusy),
    .sfActive(sfActive), .txActive(txActive)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pushByte(input logic [7:0] d, input logic l);
    @(negedge clk);
    wrValid = 1; wrData = d; wrLast = l;
    while (!wrReady) @(negedge clk);
    @(negedge clk);
    wrValid = 0; wrLast = 0;
  endtask

  task automatic popByte(output logic [7:0] d, output logic f, output logic l);
    @(negedge clk);
    rdReady = 1;
    while (!rdValid) @(negedge clk);
    d = rdData; f = rdFirst; l = rdLast;
    @(negedge clk);
    rdReady = 0;
  endtask

  task automatic ctrlCmd(input logic fl, input logic sf, input logic [2:0] th);
    @(negedge clk);
    ctrlWrite = 1; ctrlFlush = fl; ctrlStoreFwd = sf; ctrlThresh = th;
    @(negedge clk);
    ctrlWrite = 0; ctrlFlush = 0;
  endtask

  // Reads n bytes expecting base+i, first marker on byte 0, last marker on byte n-1.
  task automatic drainFrame(input string req, input int n, input logic [7:0] base);
    logic [7:0] d; logic f, l;
    for (int i = 0; i < n; i++) begin
      popByte(d, f, l);
      chk({req, " data"}, d, 8'(base + i));
      chk({req, " rdFirst"}, f, (i == 0) ? 1 : 0);
      chk({req, " rdLast"}, l, (i == n - 1) ? 1 : 0);
    end
  endtask

  task automatic testReset();
    chk("R1 wrReady", wrReady, 1);
    chk("R1 rdValid", rdValid, 0);
    chk("R1 flushBusy", flushBusy, 0);
    chk("R1 sfActive", sfActive, 0);
  endtask

  task automatic testWholeFrame();
    ctrlCmd(0, 1, 3'd7);
    idle(2);
    chk("R2 mode applied", sfActive, 1);
    for (int i = 0; i < 20; i++) pushByte(8'(8'h10 + i), 0);
    idle(3);
    chk("R3 partial frame held despite level 16", rdValid, 0);
    pushByte(8'h24, 1);
    idle(3);
    chk("R2 start after end byte", rdValid, 1);
    drainFrame("R6 whole frame", 21, 8'h10);
    idle(2);
    chk("R7 tx ends after last", txActive, 0);
    chk("R7 no valid after frame", rdValid, 0);
  endtask

  task automatic testLevel();
    ctrlCmd(0, 0, 3'd7);
    idle(2);
    for (int i = 0; i < 15; i++) pushByte(8'(8'h40 + i), 0);
    idle(3);
    chk("R4 below level 16", rdValid, 0);
    pushByte(8'h4F, 0);
    idle(3);
    chk("R4 level 16 reached", rdValid, 1);
    pushByte(8'h50, 1);
    drainFrame("R4 level frame", 17, 8'h40);
  endtask

  task automatic testShortFrame();
    ctrlCmd(0, 0, 3'd0);
    idle(2);
    for (int i = 0; i < 4; i++) pushByte(8'(8'h60 + i), 0);
    idle(3);
    chk("R4 below level 64", rdValid, 0);
    pushByte(8'h64, 1);
    idle(3);
    chk("R5 short complete frame starts", rdValid, 1);
    drainFrame("R5 short frame", 5, 8'h60);
  endtask

  task automatic testBackToBack();
    ctrlCmd(0, 1, 3'd7);
    idle(2);
    for (int i = 0; i < 3; i++) pushByte(8'(8'h80 + i), (i == 2));
    for (int i = 0; i < 4; i++) pushByte(8'(8'h90 + i), (i == 3));
    drainFrame("R7 frame A", 3, 8'h80);
    drainFrame("R7 frame B", 4, 8'h90);
    idle(2);
    chk("R7 idle after both", rdValid, 0);
  endtask

  task automatic testModeHold();
    ctrlCmd(0, 0, 3'd7);
    idle(2);
    for (int i = 0; i < 16; i++) pushByte(8'(8'hA0 + i), 0);
    idle(3);
    chk("R11 tx active", txActive, 1);
    ctrlCmd(0, 1, 3'd7);
    idle(3);
    chk("R11 mode held during tx", sfActive, 0);
    pushByte(8'hB0, 1);
    drainFrame("R11 frame", 17, 8'hA0);
    idle(2);
    chk("R11 mode applied when idle", sfActive, 1);
  endtask

  task automatic testFlush();
    int start, len;
    logic [7:0] d; logic f, l;
    for (int i = 0; i < 10; i++) pushByte(8'(8'hC0 + i), 0);
    ctrlCmd(1, 1, 3'd7);
    chk("R9 busy set", flushBusy, 1);
    start = cyc;
    chk("R9 wrReady low in flush", wrReady, 0);
    ctrlCmd(0, 0, 3'd7);
    chk("R10 busy not disturbed", flushBusy, 1);
    while (flushBusy) @(negedge clk);
    len = cyc - start;
    chk("R9 busy length", len, FLUSH_CYCLES);
    chk("R10 mode write ignored", sfActive, 1);
    chk("R9 wrReady after flush", wrReady, 1);
    pushByte(8'hE0, 0);
    pushByte(8'hE1, 1);
    popByte(d, f, l);
    chk("R9 old bytes gone", d, 8'hE0);
    chk("R9 first marker", f, 1);
    popByte(d, f, l);
    chk("R9 second byte", d, 8'hE1);
    chk("R9 last marker", l, 1);
  endtask

  task automatic testFull();
    for (int i = 0; i < DEPTH; i++) pushByte(8'(i), 0);
    @(negedge clk);
    chk("R8 full blocks writer", wrReady, 0);
    wrValid = 1; wrData = 8'hFF;
    idle(3);
    chk("R8 still blocked", wrReady, 0);
    chk("R3 full partial frame held", rdValid, 0);
    wrValid = 0;
    ctrlCmd(1, 1, 3'd7);
    while (flushBusy) @(negedge clk);
    chk("R9 flush frees full FIFO", wrReady, 1);
    chk("R9 nothing to read", rdValid, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1;
    idle(1);
    testReset();
    testWholeFrame();
    testLevel();
    testShortFrame();
    testBackToBack();
    testModeHold();
    testFlush();
    testFull();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule